// File: doc/BRIEF.md
# SDRAM Byte-Mask Data Path

This block sits on the device side of a 16-bit SDRAM data bus and handles the two data-mask inputs, one per byte lane. For writes it turns the mask bits into per-byte write enables for the storage array. A write enable is asserted only in the same clock that the data and mask are presented. A low mask bit lets its byte be stored. A high mask bit blocks that byte.

For reads the mask takes a different path. The block registers the mask together with a read-active flag and carries them through a two-stage pipeline that advances on every clock. At the output stage each byte lane is driven with the internal read data only if a read was active two clocks earlier and that lane's mask bit was low then. Otherwise the lane is released to high impedance: its enable is low and its data value is zero. Burst addressing and the read-data latency itself are handled outside this block. The internal read data arrives already aligned with the output stage.

Top module: `sdram_dqm_path`

## Requirements
- R1: While the write-active flag is high, a mask bit that is low in a cycle asserts that lane's write enable in the same cycle, with no register on the path.
- R2: While the write-active flag is high, a mask bit that is high in a cycle keeps that lane's write enable low in that cycle, so the lane's input data is not stored.
- R3: While the write-active flag is low, every write enable is low, whatever the mask bits are.
- R4: A mask bit sampled high at a clock edge while a read is active holds that lane's output enable low in the cycle that follows the second edge after it.
- R5: A mask bit sampled low at a clock edge while a read is active sets that lane's output enable high two clocks later. In that cycle the lane's output equals the matching bits of the internal read data.
- R6: If the read-active flag was low at the edge two clocks earlier, every output enable is low, even when the mask bits were low.
- R7: A lane whose output enable is low presents all-zero bits on the read data output.
- R8: A synchronous active-low reset clears both pipeline stages. All output enables are low in the first two cycles after reset is released, even if a read was active with the mask low during reset.
- R9: Mask bit 0 controls data bits 7:0 and output-enable bit 0. Mask bit 1 controls data bits 15:8 and output-enable bit 1. The same mapping applies to write-enable bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_active | input | 1 | High while a write burst moves data this cycle |
| rd_active | input | 1 | High while a read burst is addressed this cycle |
| dqm | input | 2 | Data-mask bits, one per byte lane, high = masked |
| rd_data | input | 16 | Internal read data aligned with the output stage |
| wr_be | output | 2 | Per-byte write enables toward the array |
| dq_out | output | 16 | Read data toward the pins, zero on released lanes |
| dq_oe | output | 2 | Per-lane output enable, low = high impedance |

## Verification
The read-side properties look two cycles into the past. They therefore assume that reset has been released for at least two edges, and they are qualified with a small counter of cycles since reset. They take no protocol restriction on the inputs: read and write flags may overlap, and the mask may change on any cycle. The stimulus exploits that freedom by randomising every input on each cycle, and by inserting mid-run resets while a read is held active with an open mask.

// File: rtl/sdm_pkg.sv
// Package: shared constants and helpers for the SDRAM byte-mask data path.
// Assumes byte-wide lanes; lane i covers data bits [i*8 +: 8].
package sdm_pkg;
    localparam int unsigned LANE_BITS   = 8;
    localparam int unsigned LANES_DEF   = 2;
    localparam int unsigned RD_LAT_DEF  = 2;

    // Width of a data bus built from the given number of byte lanes.
    function automatic int unsigned bus_width(input int unsigned lanes);
        return lanes * LANE_BITS;
    endfunction
endpackage

// File: rtl/sdm_wr_gate.sv
// Module: write-side mask gate.
// Produces per-lane write enables with zero latency from the mask bits and
// the write-active flag. Assumes the mask is presented in the same cycle as
// the write data it qualifies.
module sdm_wr_gate #(
    parameter int unsigned LANES = sdm_pkg::LANES_DEF
) (
    input  logic             wr_active,
    input  logic [LANES-1:0] dqm,
    output logic [LANES-1:0] wr_be
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: a lane is written only when a write is active and its mask is low.
        always_comb begin
            wr_be[g] = wr_active & ~dqm[g];
        end
    end
endmodule

// File: rtl/sdm_rd_delay.sv
// Module: read-side mask delay line.
// Carries the read-active flag and mask bits through RD_LAT register stages.
// The stages shift on every clock, whether or not a read is active. Reset is
// synchronous and active-low and loads every stage with "no read, all masked".
module sdm_rd_delay #(
    parameter int unsigned LANES  = sdm_pkg::LANES_DEF,
    parameter int unsigned RD_LAT = sdm_pkg::RD_LAT_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_active,
    input  logic [LANES-1:0] dqm,
    output logic             dly_vld,
    output logic [LANES-1:0] dly_msk
);
    logic             vld_q [RD_LAT];
    logic [LANES-1:0] msk_q [RD_LAT];

    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            // Purpose: capture the current read flag and mask into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    msk_q[0] <= '1;
                end else begin
                    vld_q[0] <= rd_active;
                    msk_q[0] <= dqm;
                end
            end
        end else begin : g_body
            // Purpose: advance the previous stage by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    msk_q[s] <= '1;
                end else begin
                    vld_q[s] <= vld_q[s-1];
                    msk_q[s] <= msk_q[s-1];
                end
            end
        end
    end

    // Purpose: expose the last stage as the delayed read flag and mask.
    always_comb begin
        dly_vld = vld_q[RD_LAT-1];
        dly_msk = msk_q[RD_LAT-1];
    end

    // R8: a reset edge leaves the last stage disabled
    p_reset_clears_r8: assert property (@(posedge clk)
        !rst_n |=> (!dly_vld && (dly_msk == '1)));
endmodule

// File: rtl/sdm_lane_drv.sv
// Module: per-lane read output driver.
// Combines the delayed read flag and mask into per-lane output enables and
// gates the internal read data. A released lane drives zeros, and its
// enable tells the pad logic to float the lane.
module sdm_lane_drv #(
    parameter int unsigned LANES = sdm_pkg::LANES_DEF,
    localparam int unsigned BW   = sdm_pkg::LANE_BITS,
    localparam int unsigned DW   = sdm_pkg::bus_width(LANES)
) (
    input  logic             dly_vld,
    input  logic [LANES-1:0] dly_msk,
    input  logic [DW-1:0]    rd_data,
    output logic [DW-1:0]    dq_out,
    output logic [LANES-1:0] dq_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: enable a lane when a delayed read is valid and unmasked.
        always_comb begin
            dq_oe[g] = dly_vld & ~dly_msk[g];
        end
        // Purpose: pass the lane's read byte only while it is enabled.
        always_comb begin
            dq_out[g*BW +: BW] = dq_oe[g] ? rd_data[g*BW +: BW] : '0;
        end
    end

    // R7: a released lane never carries data
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            if (!dq_oe[i]) begin
                a_quiet_lane_r7: assert (dq_out[i*BW +: BW] == '0);
            end
        end
    end
endmodule

// File: rtl/sdram_dqm_path.sv
// Module: top of the SDRAM byte-mask data path.
// The write mask acts in the same clock as the data. The read mask is delayed
// by RD_LAT clocks and then enables or releases each byte lane. Assumes the
// internal read data is already aligned with the output stage.
module sdram_dqm_path #(
    parameter int unsigned LANES  = sdm_pkg::LANES_DEF,
    parameter int unsigned RD_LAT = sdm_pkg::RD_LAT_DEF,
    localparam int unsigned DW    = sdm_pkg::bus_width(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_active,
    input  logic             rd_active,
    input  logic [LANES-1:0] dqm,
    input  logic [DW-1:0]    rd_data,
    output logic [LANES-1:0] wr_be,
    output logic [DW-1:0]    dq_out,
    output logic [LANES-1:0] dq_oe
);
    logic             dly_vld;
    logic [LANES-1:0] dly_msk;

    sdm_wr_gate #(.LANES(LANES)) u_wr (
        .wr_active (wr_active),
        .dqm       (dqm),
        .wr_be     (wr_be)
    );

    sdm_rd_delay #(.LANES(LANES), .RD_LAT(RD_LAT)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_active (rd_active),
        .dqm       (dqm),
        .dly_vld   (dly_vld),
        .dly_msk   (dly_msk)
    );

    sdm_lane_drv #(.LANES(LANES)) u_drv (
        .dly_vld   (dly_vld),
        .dly_msk   (dly_msk),
        .rd_data   (rd_data),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    // Purpose: count cycles since reset, saturating, to qualify past-looking checks.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R3: no write enable without an active write
    p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_active |-> (wr_be == '0));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R2: a masked lane is never written
        p_masked_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_active && dqm[g]) |-> !wr_be[g]);
        // R1: an open lane is written in the same cycle
        p_open_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_active && !dqm[g]) |-> wr_be[g]);
    end

    if (RD_LAT == 2) begin : g_lat2_chk
        // R6: no drive when no read was active two edges back
        p_idle_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q >= 2'd2 && !$past(rd_active, 2)) |-> (dq_oe == '0));
        for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
            // R4: masked read lane floats two clocks later
            p_mask_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 2'd2 && $past(dqm[g], 2)) |-> !dq_oe[g]);
            // R5: unmasked read lane drives two clocks later
            p_open_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q >= 2'd2 && $past(rd_active, 2) && !$past(dqm[g], 2))
                |-> dq_oe[g]);
        end
    end
endmodule

// File: tb/tb_sdram_dqm_path.sv
module tb_sdram_dqm_path;
    localparam int PERIOD = 10;
    localparam int LANES  = 2;
    localparam int DW     = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_active = 1'b0;
    logic            rd_active = 1'b0;
    logic [1:0]      dqm = 2'b11;
    logic [DW-1:0]   rd_data = '0;
    logic [1:0]      wr_be;
    logic [DW-1:0]   dq_out;
    logic [1:0]      dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the two delay stages: {valid, mask}
    logic [2:0] h1 = 3'b011;
    logic [2:0] h2 = 3'b011;

    sdram_dqm_path dut (
        .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .rd_active(rd_active),
        .dqm(dqm), .rd_data(rd_data), .wr_be(wr_be), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [1:0] f_be(input logic wa, input logic [1:0] m);
        return wa ? ~m : 2'b00;
    endfunction

    function automatic logic [1:0] f_oe(input logic [2:0] st);
        return st[2] ? ~st[1:0] : 2'b00;
    endfunction

    function automatic logic [DW-1:0] f_out(input logic [1:0] oe, input logic [DW-1:0] d);
        return {oe[1] ? d[15:8] : 8'h00, oe[0] ? d[7:0] : 8'h00};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at negedge, then check all outputs, then model the next rising edge
    task automatic step(input logic rs, input logic wa, input logic ra,
                        input logic [1:0] m, input logic [DW-1:0] d);
        logic [1:0] eoe;
        @(negedge clk);
        rst_n = rs; wr_active = wa; rd_active = ra; dqm = m; rd_data = d;
        #1;
        if (rs) begin
            if (!wa)                check("R3 write enables idle", {14'b0, wr_be}, {14'b0, f_be(wa, m)});
            else if (m == 2'b01 || m == 2'b10)
                                    check("R9 lane mapping of write enables", {14'b0, wr_be}, {14'b0, f_be(wa, m)});
            else if (m == 2'b11)    check("R2 masked write", {14'b0, wr_be}, {14'b0, f_be(wa, m)});
            else                    check("R1 open write", {14'b0, wr_be}, {14'b0, f_be(wa, m)});
        end
        eoe = f_oe(h2);
        if (!h2[2])                 check("R6 no read two clocks back", {14'b0, dq_oe}, {14'b0, eoe});
        else if (h2[1:0] == 2'b11)  check("R4 masked read lanes", {14'b0, dq_oe}, {14'b0, eoe});
        else if (h2[1:0] == 2'b00)  check("R5 open read lanes", {14'b0, dq_oe}, {14'b0, eoe});
        else                        check("R9 lane mapping of output enables", {14'b0, dq_oe}, {14'b0, eoe});
        if (eoe == 2'b11)           check("R5 read data passes", dq_out, f_out(eoe, d));
        else                        check("R7 released lanes read zero", dq_out, f_out(eoe, d));
        @(posedge clk);
        if (!rs) begin h1 = 3'b011; h2 = 3'b011; end
        else begin h2 = h1; h1 = {ra, m}; end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // reset with a read held open: R8
        step(1'b0, 1'b1, 1'b1, 2'b00, 16'hA5C3);
        step(1'b0, 1'b1, 1'b1, 2'b00, 16'hA5C3);
        step(1'b1, 1'b0, 1'b1, 2'b00, 16'h1234);
        check("R8 output enables off after reset", {14'b0, dq_oe}, 16'h0);
        step(1'b1, 1'b0, 1'b1, 2'b00, 16'h5678);
        check("R8 second cycle after reset still off", {14'b0, dq_oe}, 16'h0);
        // directed corners for R4, R5, R6, R9
        step(1'b1, 1'b1, 1'b1, 2'b11, 16'hFFFF);
        step(1'b1, 1'b1, 1'b1, 2'b01, 16'hBEEF);
        step(1'b1, 1'b0, 1'b1, 2'b10, 16'hCAFE);
        step(1'b1, 1'b0, 1'b0, 2'b00, 16'h0F0F);
        step(1'b1, 1'b1, 1'b0, 2'b00, 16'hF00D);
        step(1'b1, 1'b0, 1'b0, 2'b00, 16'h1111);
        step(1'b1, 1'b0, 1'b0, 2'b11, 16'h2222);
        // constrained random traffic with occasional resets
        for (int i = 0; i < 3000; i++) begin
            logic rs;
            rs = ($urandom % 97) != 0;
            step(rs, 1'(($urandom % 3) != 0), 1'(($urandom % 3) != 0),
                 2'($urandom), 16'($urandom));
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule